// File: doc/BRIEF.md
# Write Completion Status Reporter

This block sits on the read path of a nonvolatile byte memory. While the memory's internal programming cycle runs, a host that polls the data bus must learn when the cycle has ended, and there is no separate ready pin. During that time every read returns a status byte instead of array contents. The status byte carries two independent completion indicators. The top data bit is the inverse of the top bit of the byte last written. The bit below it changes value from one read to the next. Once the programming cycle finishes, reads return the array data unchanged.

A host can poll in either of two ways. It can compare the top bit with the top bit of the byte it wrote, and stop when they match. It can also read twice and stop when the alternating bit no longer differs between the two reads. The level at which the alternating bit starts or stops is not fixed, so only the comparison of two reads is meaningful. After polling shows completion, the host should wait at least 10 µs before it starts another write. The write path, the storage array and that host wait are outside this block. The block receives the busy flag, a write strobe with the top bit of the written byte, and the array read data. It drives the data value and the enable for the bus drivers.

Top module: `wsr_status_reporter`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `bus_oe` is 0 and `bus_dout` is 0. The alternating status bit is 0 when reset ends.
- R2: A read is active only while both `chip_sel` and `out_en` are 1. `bus_oe` follows the read-active condition with one cycle of delay. If either input is low, `bus_oe` becomes 0 one cycle later.
- R3: Whenever `bus_oe` is 0, `bus_dout` is all zeros.
- R4: During a read with `prog_busy` at 0, `bus_dout` equals the `arr_rdata` value of the previous cycle.
- R5: During a read with `prog_busy` at 1, bit DATA_W-1 (bit 7 by default) of `bus_dout` is the inverse of the `wr_data_msb` value captured by the most recent `wr_stb` pulse.
- R6: During a read with `prog_busy` at 1, bit DATA_W-2 (bit 6) of `bus_dout` carries the alternating bit. This bit inverts when a read ends while `prog_busy` is 1, so two successive busy reads show opposite values.
- R7: During a read with `prog_busy` at 1, bits DATA_W-3 down to 0 (bits 5 to 0) of `bus_dout` are 0.
- R8: A read that ends while `prog_busy` is 0 leaves the alternating bit unchanged, so toggling stops once programming completes.
- R9: Within one uninterrupted busy read, with no write strobe, `bus_dout` stays constant. The alternating bit advances only when the read ends.
- R10: If `prog_busy` falls while a read is active, `bus_dout` shows array data from the next cycle on, without the read having to end first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_sel | input | 1 | Device selected (active high) |
| out_en | input | 1 | Output enable request (active high) |
| prog_busy | input | 1 | Internal programming cycle in progress |
| wr_stb | input | 1 | One-cycle pulse for each accepted byte write |
| wr_data_msb | input | 1 | Top bit of the byte being written, valid with `wr_stb` |
| arr_rdata | input | DATA_W | Array data for the current read address |
| bus_dout | output | DATA_W | Value driven onto the data bus |
| bus_oe | output | 1 | Data bus driver enable; 0 means high impedance |

## Verification
Four behaviours are checked by properties on every cycle. The first is that the driver enable follows the read condition one cycle later, and the second is that the bus is all zeros whenever it is not driven. The third is that the reserved status bits are 0 and array data passes through unchanged when the device is idle. The fourth is that the status word stays constant through a long busy read. The inverted top bit depends on the most recent write, and the alternating bit depends on the history of read endings while busy. Both therefore come from the bench's reference model and its scripted sequences. These sequences include reads separated by idle periods, two different written top bits, and busy falling in the middle of a read.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
    localparam int unsigned DEF_DATA_W = 8;

    typedef enum logic [1:0] {
        SRC_QUIET  = 2'd0,
        SRC_ARRAY  = 2'd1,
        SRC_STATUS = 2'd2
    } src_e;
endpackage

// File: rtl/wsr_poll_latch.sv
module wsr_poll_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    input  logic wr_msb,
    output logic msb_q
);
    typedef struct packed {
        logic msb;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_stb) begin
            st_d.msb = wr_msb;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign msb_q = st_q.msb;
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act,
    input  logic busy,
    output logic tog_q
);
    typedef struct packed {
        logic tog;
        logic rd_prev;
    } st_t;

    st_t  st_d, st_q;
    logic rd_end;

    always_comb begin
        st_d         = st_q;
        rd_end       = st_q.rd_prev && !rd_act;
        st_d.rd_prev = rd_act;
        if (rd_end && busy) begin
            st_d.tog = ~st_q.tog;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tog_q = st_q.tog;
endmodule

// File: rtl/wsr_out.sv
module wsr_out #(
    parameter int unsigned DATA_W = wsr_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wsr_pkg::src_e     src,
    input  logic [DATA_W-1:0] status_word,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] dout_q,
    output logic              oe_q
);
    import wsr_pkg::*;

    typedef struct packed {
        logic              oe;
        logic [DATA_W-1:0] dout;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = '0;
        unique case (src)
            SRC_ARRAY: begin
                st_d.oe   = 1'b1;
                st_d.dout = arr_rdata;
            end
            SRC_STATUS: begin
                st_d.oe   = 1'b1;
                st_d.dout = status_word;
            end
            default: begin
                st_d.oe   = 1'b0;
                st_d.dout = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout_q = st_q.dout;
    assign oe_q   = st_q.oe;
endmodule

// File: rtl/wsr_status_reporter.sv
module wsr_status_reporter #(
    parameter int unsigned DATA_W = wsr_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chip_sel,
    input  logic              out_en,
    input  logic              prog_busy,
    input  logic              wr_stb,
    input  logic              wr_data_msb,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic [DATA_W-1:0] bus_dout,
    output logic              bus_oe
);
    import wsr_pkg::*;

    localparam int unsigned POLL_BIT = DATA_W - 1;
    localparam int unsigned TOG_BIT  = DATA_W - 2;

    logic              rd_act;
    logic              last_msb;
    logic              tog;
    logic [DATA_W-1:0] status_word;
    src_e              src;

    assign rd_act = chip_sel && out_en;

    wsr_poll_latch u_poll (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .wr_msb (wr_data_msb),
        .msb_q  (last_msb)
    );

    wsr_toggle u_tog (
        .clk    (clk),
        .rst_n  (rst_n),
        .rd_act (rd_act),
        .busy   (prog_busy),
        .tog_q  (tog)
    );

    always_comb begin
        status_word           = '0;
        status_word[POLL_BIT] = ~last_msb;
        status_word[TOG_BIT]  = tog;
        if (!rd_act) begin
            src = SRC_QUIET;
        end else if (prog_busy) begin
            src = SRC_STATUS;
        end else begin
            src = SRC_ARRAY;
        end
    end

    wsr_out #(.DATA_W(DATA_W)) u_out (
        .clk         (clk),
        .rst_n       (rst_n),
        .src         (src),
        .status_word (status_word),
        .arr_rdata   (arr_rdata),
        .dout_q      (bus_dout),
        .oe_q        (bus_oe)
    );
endmodule

// File: rtl/wsr_status_reporter_chk.sv
module wsr_status_reporter_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              chip_sel,
    input logic              out_en,
    input logic              prog_busy,
    input logic              wr_stb,
    input logic [DATA_W-1:0] arr_rdata,
    input logic [DATA_W-1:0] bus_dout,
    input logic              bus_oe
);
    logic rd_act;
    assign rd_act = chip_sel && out_en;

    p_oe_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act |=> bus_oe);

    p_oe_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act |=> !bus_oe);

    p_quiet_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_oe |-> bus_dout == '0);

    p_array_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && !prog_busy) |=> bus_dout == $past(arr_rdata));

    p_reserved_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy) |=> bus_dout[DATA_W-3:0] == '0);

    p_status_steady_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_act && prog_busy && $past(rd_act) && $past(prog_busy) && !$past(wr_stb))
        |=> $stable(bus_dout));
endmodule

bind wsr_status_reporter wsr_status_reporter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .chip_sel  (chip_sel),
    .out_en    (out_en),
    .prog_busy (prog_busy),
    .wr_stb    (wr_stb),
    .arr_rdata (arr_rdata),
    .bus_dout  (bus_dout),
    .bus_oe    (bus_oe)
);

// File: tb/wsr_status_reporter_bench.sv
module wsr_status_reporter_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chip_sel = 1'b0;
    logic       out_en = 1'b0;
    logic       prog_busy = 1'b0;
    logic       wr_stb = 1'b0;
    logic       wr_data_msb = 1'b0;
    logic [7:0] arr_rdata = 8'h00;
    logic [7:0] bus_dout;
    logic       bus_oe;

    int    checks = 0;
    int    failures = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    // behavioural reference state
    logic [7:0] m_dout = 8'h00;
    logic       m_oe = 1'b0;
    logic       m_tog = 1'b0;
    logic       m_last = 1'b0;
    logic       m_inread = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wsr_status_reporter u_wsr_status_reporter (
        .clk         (clk),
        .rst_n       (rst_n),
        .chip_sel    (chip_sel),
        .out_en      (out_en),
        .prog_busy   (prog_busy),
        .wr_stb      (wr_stb),
        .wr_data_msb (wr_data_msb),
        .arr_rdata   (arr_rdata),
        .bus_dout    (bus_dout),
        .bus_oe      (bus_oe)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_dout = 8'h00; m_oe = 1'b0; m_tog = 1'b0; m_last = 1'b0; m_inread = 1'b0;
        end else begin
            bit reading;
            reading = chip_sel && out_en;
            if (!reading)      m_dout = 8'h00;
            else if (prog_busy) m_dout = {~m_last, m_tog, 6'b000000};
            else               m_dout = arr_rdata;
            m_oe = reading;
            if (m_inread && !reading && prog_busy) m_tog = ~m_tog;
            m_inread = reading;
            if (wr_stb) m_last = wr_data_msb;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            check({cur_tag, " oe"}, {7'b0, bus_oe}, {7'b0, m_oe});
            check({cur_tag, " dout"}, bus_dout, m_dout);
        end
    end

    task automatic do_write(input logic msb);
        wr_stb = 1'b1; wr_data_msb = msb;
        @(negedge clk);
        wr_stb = 1'b0;
        @(negedge clk);
    endtask

    task automatic do_read(input int n, output logic [7:0] first, output logic [7:0] last);
        chip_sel = 1'b1; out_en = 1'b1;
        @(negedge clk);
        first = bus_dout;
        for (int i = 1; i < n; i++) @(negedge clk);
        last = bus_dout;
        chip_sel = 1'b0; out_en = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] a, b;
        repeat (3) @(negedge clk);
        check("R1 oe in reset", {7'b0, bus_oe}, 8'h00);
        check("R1 dout in reset", bus_dout, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 oe after reset", {7'b0, bus_oe}, 8'h00);

        cur_tag = "R2";
        chip_sel = 1'b1; @(negedge clk); @(negedge clk);
        check("R2 select only", {7'b0, bus_oe}, 8'h00);
        chip_sel = 1'b0; out_en = 1'b1; @(negedge clk); @(negedge clk);
        check("R2 enable only", {7'b0, bus_oe}, 8'h00);
        out_en = 1'b0; @(negedge clk);

        cur_tag = "R4";
        arr_rdata = 8'h5A; do_read(1, a, b);
        check("R4 idle read", a, 8'h5A);
        check("R3 quiet after read", bus_dout, 8'h00);
        arr_rdata = 8'hC3; do_read(2, a, b);
        check("R4 idle read 2", b, 8'hC3);

        cur_tag = "R5";
        do_write(1'b0);
        prog_busy = 1'b1;
        do_read(3, a, b);
        check("R5 R7 first busy read", a, 8'h80);
        check("R9 steady within read", b, 8'h80);
        cur_tag = "R6";
        do_read(1, a, b);
        check("R6 second busy read flips", a, 8'hC0);
        do_write(1'b1);
        cur_tag = "R5";
        do_read(1, a, b);
        check("R5 inverted top bit of 1", a, 8'h00);

        cur_tag = "R8";
        prog_busy = 1'b0; arr_rdata = 8'h3C;
        do_read(1, a, b);
        check("R8 idle read data", a, 8'h3C);
        prog_busy = 1'b1;
        do_read(1, a, b);
        check("R8 toggle held across idle read", a, 8'h40);

        cur_tag = "R10";
        arr_rdata = 8'h77;
        chip_sel = 1'b1; out_en = 1'b1;
        @(negedge clk);
        check("R10 status before drop", bus_dout, 8'h00);
        prog_busy = 1'b0;
        @(negedge clk);
        check("R10 array after drop", bus_dout, 8'h77);
        chip_sel = 1'b0; out_en = 1'b0;
        @(negedge clk);
        prog_busy = 1'b1;
        do_read(1, a, b);
        check("R8 no flip on idle end", a, 8'h00);
        prog_busy = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule